// File: doc/BRIEF.md
# Virtual Supervisor Interrupt View Registers

This block sits beside a hart's hypervisor CSR file. It holds the hypervisor's virtual-interrupt enable register, its virtual-interrupt pending register and the virtual interrupt control register. From these and from the delegation mask, it derives the pending and enable vectors that a guest running at virtual supervisor level sees for major interrupts 0 to 63. For each guest bit, a rule picks one of three sources: an alias of the real supervisor register, a bit held locally, or a constant zero. The rule depends on the delegation bit and the virtual-enable bit for that interrupt number.

Accesses use a single CSR port. The port carries a select code, a write flag, write data and a flag for guest privilege. Reads return data combinationally. A write to an aliased bit is passed on as a per-bit write mask to the real supervisor pending or enable register, and the write data for it is taken from `csr_wdata`. When the trap control bit of the control register is set, some guest accesses are refused. The block raises a virtual instruction exception flag for those accesses and suppresses any write they would have made.

Top module: `vsirq_virt_csr`

## Requirements
- R1: For interrupt numbers 13 to 63 with the delegation bit set, the guest pending and enable bits equal `sup_pend` and `sup_en`. A write of the guest pending view (select 3) or guest enable view (select 4) raises exactly those delegated bits in `sup_pend_wmask` or `sup_en_wmask`.
- R2: For 13 to 63 with the delegation bit clear and the virtual-enable bit set, the guest pending bit shows the virtual-pending bit, and a guest pending write updates it. The guest enable bit is a locally held bit that can be written.
- R3: For 13 to 63 with both the delegation bit and the virtual-enable bit clear, the guest pending and enable bits read zero and ignore writes.
- R4: The virtual-enable register (select 0) reads zero in bits 12:0. Only the bits set in parameter VEN_WR can be written; the default VEN_WR is 0x0000_FFFF_00FF_E000. The bits set in VEN_ONE always read one.
- R5: The virtual-pending register (select 1) can be written in bits 2, 6 and 10, and in each bit from 13 to 63 whose virtual-enable bit is not hardwired to zero. All its other bits read zero.
- R6: The control register (select 2) places the trap bit at 30, a 6-bit identity at 21:16, a rank bit at 9, a mode bit at 8 and an 8-bit priority at 7:0. Bits 27:22 and all other bits read zero.
- R7: When the trap bit is 1, a guest access of either kind to select 3 or 4, or a guest write to the timer-compare select 5, asserts `virt_instr_trap` in the same cycle. That access reads zero and writes nothing. Host accesses never trap.
- R8: Virtual-pending bits 2 and 13 to 23 change only through a write to select 1 or select 3.
- R9: Guest bits 1, 5 and 9 show virtual-pending bits 2, 6 and 10 while delegation bits 2, 6 and 10 are set, and they read zero otherwise. The guest enable bits 1, 5 and 9 are held locally under the same condition. A guest pending write reaches virtual-pending bit 2 through guest bit 1.
- R10: A locally held guest enable bit reads zero on the first cycle after its source changes into the locally held kind.
- R11: Reads and the trap flag respond in the cycle of the request. Writes take effect at the next rising edge. A synchronous active-high `rst` clears all state. Select codes 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| deleg_mask | input | 64 | Delegation mask, one bit per interrupt number |
| sup_pend | input | 64 | Real supervisor pending vector |
| sup_en | input | 64 | Real supervisor enable vector |
| csr_req | input | 1 | Access request |
| csr_we | input | 1 | Request is a write |
| csr_sel | input | 3 | Register select: 0 vie, 1 vip, 2 control, 3 guest pending, 4 guest enable, 5 timer compare |
| csr_wdata | input | 64 | Write data |
| guest_mode | input | 1 | Request comes from guest privilege |
| csr_rdata | output | 64 | Read data, combinational |
| virt_instr_trap | output | 1 | Access must raise a virtual instruction exception |
| guest_pend | output | 64 | Guest-visible pending vector |
| guest_en | output | 64 | Guest-visible enable vector |
| sup_pend_wmask | output | 64 | Bits of the real pending register to load from csr_wdata |
| sup_en_wmask | output | 64 | Bits of the real enable register to load from csr_wdata |

## Verification
`csr_rdata`, `virt_instr_trap`, the guest views and both write masks are combinational. They are due in the same cycle as the inputs that cause them. Register writes and the clearing of a locally held enable bit appear one rising edge later. The bench changes its inputs on the falling edge and compares every output 1 ns later against its model. The model is advanced only at the rising edge, so each expected value carries exactly the one-edge delay that the requirements give.

// File: rtl/vsirq_pkg.sv
package vsirq_pkg;

    localparam int XLEN     = 64;
    localparam int IID_W    = 6;
    localparam int LOW_SPAN = 13;
    localparam int IID_LSB  = 16;

    localparam logic [XLEN-1:0] HI_MASK       = ~((XLEN'(1) << LOW_SPAN) - XLEN'(1));
    localparam logic [XLEN-1:0] LOW_PEND_MASK = (XLEN'(1) << 2) | (XLEN'(1) << 6) | (XLEN'(1) << 10);

    typedef enum logic [2:0] {
        SEL_VEN   = 3'd0,
        SEL_VPEND = 3'd1,
        SEL_VCTL  = 3'd2,
        SEL_GPEND = 3'd3,
        SEL_GEN   = 3'd4,
        SEL_TCMP  = 3'd5
    } csr_sel_e;

    typedef enum logic [1:0] {
        LK_NONE,
        LK_HI,
        LK_LOW
    } lane_kind_e;

    typedef struct packed {
        logic             vti;
        logic [IID_W-1:0] iid;
        logic             dpr;
        logic             ipriom;
        logic [7:0]       iprio;
    } vctl_t;

    typedef struct packed {
        logic ven;
        logic vpend;
        logic vctl;
        logic gpend;
        logic gen;
    } csr_wr_t;

    function automatic lane_kind_e lane_kind(input int idx);
        if (idx >= LOW_SPAN)
            return LK_HI;
        if (idx == 1 || idx == 5 || idx == 9)
            return LK_LOW;
        return LK_NONE;
    endfunction

    function automatic logic [XLEN-1:0] vctl_pack(input vctl_t c);
        logic [XLEN-1:0] r;
        r = '0;
        r[30]                 = c.vti;
        r[IID_LSB +: IID_W]   = c.iid;
        r[9]                  = c.dpr;
        r[8]                  = c.ipriom;
        r[7:0]                = c.iprio;
        return r;
    endfunction

    function automatic vctl_t vctl_unpack(input logic [XLEN-1:0] w);
        vctl_t c;
        c.vti    = w[30];
        c.iid    = w[IID_LSB +: IID_W];
        c.dpr    = w[9];
        c.ipriom = w[8];
        c.iprio  = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/vsirq_access.sv
module vsirq_access
    import vsirq_pkg::*;
(
    input  logic     req,
    input  logic     we,
    input  csr_sel_e sel,
    input  logic     guest_mode,
    input  logic     vti,
    output logic     trap,
    output csr_wr_t  wr
);

    logic guarded_view;
    logic guarded_tcmp;
    logic wr_ok;

    assign guarded_view = (sel == SEL_GPEND) || (sel == SEL_GEN);
    assign guarded_tcmp = (sel == SEL_TCMP) && we;
    assign trap         = req && guest_mode && vti && (guarded_view || guarded_tcmp);
    assign wr_ok        = req && we && !trap;

    always_comb begin
        wr       = '0;
        wr.ven   = wr_ok && (sel == SEL_VEN);
        wr.vpend = wr_ok && (sel == SEL_VPEND);
        wr.vctl  = wr_ok && (sel == SEL_VCTL);
        wr.gpend = wr_ok && (sel == SEL_GPEND);
        wr.gen   = wr_ok && (sel == SEL_GEN);
    end

endmodule

// File: rtl/vsirq_hregs.sv
module vsirq_hregs
    import vsirq_pkg::*;
#(
    parameter logic [XLEN-1:0] VEN_WR  = 64'h0000_FFFF_00FF_E000,
    parameter logic [XLEN-1:0] VEN_ONE = 64'h0
)(
    input  logic            clk,
    input  logic            rst,
    input  csr_wr_t         wr,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] gw_mask,
    input  logic [XLEN-1:0] gw_data,
    output logic [XLEN-1:0] ven,
    output logic [XLEN-1:0] vpend,
    output vctl_t           vctl
);

    localparam logic [XLEN-1:0] VEN_WR_EFF  = VEN_WR & HI_MASK;
    localparam logic [XLEN-1:0] VEN_ONE_EFF = VEN_ONE & HI_MASK;
    localparam logic [XLEN-1:0] VPEND_MASK  = LOW_PEND_MASK | ((VEN_WR | VEN_ONE) & HI_MASK);

    logic [XLEN-1:0] ven_q;
    logic [XLEN-1:0] vpend_q;
    vctl_t           vctl_q;
    logic [XLEN-1:0] gw_eff;

    assign gw_eff = gw_mask & VPEND_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            ven_q   <= '0;
            vpend_q <= '0;
            vctl_q  <= '0;
        end else begin
            if (wr.ven)
                ven_q <= wdata & VEN_WR_EFF;
            if (wr.vpend)
                vpend_q <= wdata & VPEND_MASK;
            else
                vpend_q <= (vpend_q & ~gw_eff) | (gw_data & gw_eff);
            if (wr.vctl)
                vctl_q <= vctl_unpack(wdata);
        end
    end

    assign ven   = ven_q | VEN_ONE_EFF;
    assign vpend = vpend_q;
    assign vctl  = vctl_q;

endmodule

// File: rtl/vsirq_lane.sv
module vsirq_lane
    import vsirq_pkg::*;
#(
    parameter int IDX = 13
)(
    input  logic clk,
    input  logic rst,
    input  logic deleg_bit,
    input  logic ven_bit,
    input  logic vpend_bit,
    input  logic sup_pend_bit,
    input  logic sup_en_bit,
    input  logic gpend_wr,
    input  logic gen_wr,
    input  logic wdata_bit,
    output logic gpend_bit,
    output logic gen_bit,
    output logic vpend_we,
    output logic sup_pend_we,
    output logic sup_en_we
);

    localparam lane_kind_e KIND     = lane_kind(IDX);
    localparam bit         IS_HI    = (KIND == LK_HI);
    localparam bit         GUEST_PW = IS_HI || (IDX == 1);

    logic alias_sel;
    logic own_sel;
    logic gen_q;

    assign alias_sel = IS_HI && deleg_bit;
    assign own_sel   = IS_HI ? (!deleg_bit && ven_bit) : deleg_bit;

    always_ff @(posedge clk) begin
        if (rst)
            gen_q <= 1'b0;
        else if (!own_sel)
            gen_q <= 1'b0;
        else if (gen_wr)
            gen_q <= wdata_bit;
    end

    assign gpend_bit   = alias_sel ? sup_pend_bit : (own_sel && vpend_bit);
    assign gen_bit     = alias_sel ? sup_en_bit   : (own_sel && gen_q);
    assign vpend_we    = GUEST_PW && gpend_wr && own_sel;
    assign sup_pend_we = gpend_wr && alias_sel;
    assign sup_en_we   = gen_wr && alias_sel;

endmodule

// File: rtl/vsirq_virt_csr.sv
module vsirq_virt_csr
    import vsirq_pkg::*;
#(
    parameter logic [63:0] VEN_WR  = 64'h0000_FFFF_00FF_E000,
    parameter logic [63:0] VEN_ONE = 64'h0
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] deleg_mask,
    input  logic [63:0] sup_pend,
    input  logic [63:0] sup_en,
    input  logic        csr_req,
    input  logic        csr_we,
    input  logic [2:0]  csr_sel,
    input  logic [63:0] csr_wdata,
    input  logic        guest_mode,
    output logic [63:0] csr_rdata,
    output logic        virt_instr_trap,
    output logic [63:0] guest_pend,
    output logic [63:0] guest_en,
    output logic [63:0] sup_pend_wmask,
    output logic [63:0] sup_en_wmask
);

    csr_sel_e        sel_e;
    csr_wr_t         wr_s;
    vctl_t           vctl_v;
    logic [XLEN-1:0] ven_v;
    logic [XLEN-1:0] vpend_v;
    logic [XLEN-1:0] lane_vpwe;
    logic [XLEN-1:0] gw_mask;
    logic [XLEN-1:0] gw_data;
    logic            unused_bits;

    assign sel_e       = csr_sel_e'(csr_sel);
    assign unused_bits = ^{deleg_mask, sup_pend, sup_en};

    vsirq_access u_access (
        .req        (csr_req),
        .we         (csr_we),
        .sel        (sel_e),
        .guest_mode (guest_mode),
        .vti        (vctl_v.vti),
        .trap       (virt_instr_trap),
        .wr         (wr_s)
    );

    vsirq_hregs #(
        .VEN_WR  (VEN_WR),
        .VEN_ONE (VEN_ONE)
    ) u_hregs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_s),
        .wdata   (csr_wdata),
        .gw_mask (gw_mask),
        .gw_data (gw_data),
        .ven     (ven_v),
        .vpend   (vpend_v),
        .vctl    (vctl_v)
    );

    for (genvar i = 0; i < XLEN; i++) begin : g_lane
        if (lane_kind(i) == LK_HI) begin : g_hi
            vsirq_lane #(.IDX(i)) u_lane (
                .clk          (clk),
                .rst          (rst),
                .deleg_bit    (deleg_mask[i]),
                .ven_bit      (ven_v[i]),
                .vpend_bit    (vpend_v[i]),
                .sup_pend_bit (sup_pend[i]),
                .sup_en_bit   (sup_en[i]),
                .gpend_wr     (wr_s.gpend),
                .gen_wr       (wr_s.gen),
                .wdata_bit    (csr_wdata[i]),
                .gpend_bit    (guest_pend[i]),
                .gen_bit      (guest_en[i]),
                .vpend_we     (lane_vpwe[i]),
                .sup_pend_we  (sup_pend_wmask[i]),
                .sup_en_we    (sup_en_wmask[i])
            );
        end else if (lane_kind(i) == LK_LOW) begin : g_low
            vsirq_lane #(.IDX(i)) u_lane (
                .clk          (clk),
                .rst          (rst),
                .deleg_bit    (deleg_mask[i+1]),
                .ven_bit      (1'b0),
                .vpend_bit    (vpend_v[i+1]),
                .sup_pend_bit (sup_pend[i]),
                .sup_en_bit   (sup_en[i]),
                .gpend_wr     (wr_s.gpend),
                .gen_wr       (wr_s.gen),
                .wdata_bit    (csr_wdata[i]),
                .gpend_bit    (guest_pend[i]),
                .gen_bit      (guest_en[i]),
                .vpend_we     (lane_vpwe[i]),
                .sup_pend_we  (sup_pend_wmask[i]),
                .sup_en_we    (sup_en_wmask[i])
            );
        end else begin : g_zero
            assign guest_pend[i]     = 1'b0;
            assign guest_en[i]       = 1'b0;
            assign lane_vpwe[i]      = 1'b0;
            assign sup_pend_wmask[i] = 1'b0;
            assign sup_en_wmask[i]   = 1'b0;
        end
    end

    always_comb begin
        gw_mask    = lane_vpwe & HI_MASK;
        gw_mask[2] = lane_vpwe[1];
        gw_data    = csr_wdata;
        gw_data[2] = csr_wdata[1];
    end

    always_comb begin
        csr_rdata = '0;
        if (!virt_instr_trap) begin
            case (sel_e)
                SEL_VEN:   csr_rdata = ven_v;
                SEL_VPEND: csr_rdata = vpend_v;
                SEL_VCTL:  csr_rdata = vctl_pack(vctl_v);
                SEL_GPEND: csr_rdata = guest_pend;
                SEL_GEN:   csr_rdata = guest_en;
                default:   csr_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/vsirq_virt_csr_chk.sv
module vsirq_virt_csr_chk
    import vsirq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [63:0] deleg_mask,
    input logic [63:0] sup_pend,
    input logic        csr_req,
    input logic        csr_we,
    input logic [2:0]  csr_sel,
    input logic        guest_mode,
    input logic        virt_instr_trap,
    input logic [63:0] guest_pend,
    input logic [63:0] guest_en,
    input logic [63:0] sup_pend_wmask,
    input logic [63:0] ven,
    input logic [63:0] vpend,
    input logic        vti,
    input logic        pend_wr
);

    localparam logic [63:0] STICKY = 64'h0000_0000_00FF_E004;

    AST_DELEG_PEND_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (((guest_pend ^ sup_pend) & deleg_mask & HI_MASK) == 64'h0)); // R1

    AST_WMASK_ONLY_DELEG: assert property (@(posedge clk) disable iff (rst)
        ((sup_pend_wmask & ~deleg_mask & HI_MASK) == 64'h0)); // R1

    AST_UNSOURCED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (((guest_pend | guest_en) & ~deleg_mask & ~ven & HI_MASK) == 64'h0)); // R3

    AST_TCMP_WRITE_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (csr_req && csr_we && guest_mode && vti && csr_sel == 3'd5) |-> virt_instr_trap); // R7

    AST_HOST_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        !guest_mode |-> !virt_instr_trap); // R7

    AST_TRAP_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        virt_instr_trap |=> ($stable(ven) && $stable(vpend))); // R7

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pend_wr |=> ((($past(vpend) & ~vpend) & STICKY) == 64'h0)); // R8

endmodule

bind vsirq_virt_csr vsirq_virt_csr_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .deleg_mask      (deleg_mask),
    .sup_pend        (sup_pend),
    .csr_req         (csr_req),
    .csr_we          (csr_we),
    .csr_sel         (csr_sel),
    .guest_mode      (guest_mode),
    .virt_instr_trap (virt_instr_trap),
    .guest_pend      (guest_pend),
    .guest_en        (guest_en),
    .sup_pend_wmask  (sup_pend_wmask),
    .ven             (ven_v),
    .vpend           (vpend_v),
    .vti             (vctl_v.vti),
    .pend_wr         (wr_s.vpend | wr_s.gpend)
);

// File: tb/vsirq_virt_csr_tb.sv
`timescale 1ns/1ps
module vsirq_virt_csr_tb;

    localparam logic [63:0] VEN_WR = 64'h0000_FFFF_00FF_E000;
    localparam logic [63:0] VP_WR  = 64'h0000_FFFF_00FF_E444;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] deleg_mask = '0, sup_pend = '0, sup_en = '0, csr_wdata = '0;
    logic        csr_req = 1'b0, csr_we = 1'b0, guest_mode = 1'b0;
    logic [2:0]  csr_sel = '0;
    logic [63:0] csr_rdata, guest_pend, guest_en, sup_pend_wmask, sup_en_wmask;
    logic        virt_instr_trap;

    int total = 0;
    int bad   = 0;

    logic [63:0] m_ven, m_vpend, m_gen;
    logic        m_vti, m_dpr, m_ipriom;
    logic [5:0]  m_iid;
    logic [7:0]  m_iprio;

    always #2.5 clk = ~clk;

    vsirq_virt_csr u_dut (
        .clk(clk), .rst(rst), .deleg_mask(deleg_mask), .sup_pend(sup_pend), .sup_en(sup_en),
        .csr_req(csr_req), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .guest_mode(guest_mode), .csr_rdata(csr_rdata), .virt_instr_trap(virt_instr_trap),
        .guest_pend(guest_pend), .guest_en(guest_en),
        .sup_pend_wmask(sup_pend_wmask), .sup_en_wmask(sup_en_wmask)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_alias(int i);
        return (i >= 13) && deleg_mask[i];
    endfunction

    function automatic bit m_own(int i);
        if (i >= 13) return !deleg_mask[i] && m_ven[i];
        if (i == 1 || i == 5 || i == 9) return deleg_mask[i+1];
        return 1'b0;
    endfunction

    function automatic logic [63:0] m_vctl_word();
        return {33'b0, m_vti, 2'b0, 6'b0, m_iid, 6'b0, m_dpr, m_ipriom, m_iprio};
    endfunction

    // one cycle: compare all outputs, then advance the model at the rising edge
    task automatic step();
        logic [63:0] e_gp, e_ge, e_rd, e_spw, e_sew, n_gen, n_vp;
        logic        e_trap, wok;
        #1;
        e_gp = '0; e_ge = '0; e_spw = '0; e_sew = '0;
        e_trap = csr_req && guest_mode && m_vti &&
                 (csr_sel == 3'd3 || csr_sel == 3'd4 || (csr_sel == 3'd5 && csr_we));
        wok = csr_req && csr_we && !e_trap;
        for (int i = 0; i < 64; i++) begin
            if (m_alias(i)) begin
                e_gp[i] = sup_pend[i];
                e_ge[i] = sup_en[i];
                e_spw[i] = wok && csr_sel == 3'd3;
                e_sew[i] = wok && csr_sel == 3'd4;
            end else if (m_own(i)) begin
                e_gp[i] = (i >= 13) ? m_vpend[i] : m_vpend[i+1];
                e_ge[i] = m_gen[i];
            end
        end
        case (csr_sel)
            3'd0: e_rd = m_ven;
            3'd1: e_rd = m_vpend;
            3'd2: e_rd = m_vctl_word();
            3'd3: e_rd = e_gp;
            3'd4: e_rd = e_ge;
            default: e_rd = '0;
        endcase
        if (e_trap) e_rd = '0;
        chk("R1/R2/R3/R9 guest_pend", guest_pend, e_gp);
        chk("R1/R2/R10 guest_en", guest_en, e_ge);
        chk("R7 trap", {63'b0, virt_instr_trap}, {63'b0, e_trap});
        chk("R4/R5/R6/R11 rdata", csr_rdata, e_rd);
        chk("R1 sup_pend_wmask", sup_pend_wmask, e_spw);
        chk("R1 sup_en_wmask", sup_en_wmask, e_sew);
        n_gen = '0;
        n_vp  = m_vpend;
        for (int i = 0; i < 64; i++) begin
            if (m_own(i)) begin
                n_gen[i] = (wok && csr_sel == 3'd4) ? csr_wdata[i] : m_gen[i];
                if (wok && csr_sel == 3'd3) begin
                    if (i >= 13) n_vp[i] = csr_wdata[i];
                    if (i == 1)  n_vp[2] = csr_wdata[1];
                end
            end
        end
        if (wok && csr_sel == 3'd1) n_vp = csr_wdata & VP_WR;
        @(posedge clk);
        if (rst) begin
            m_ven = '0; m_vpend = '0; m_gen = '0;
            m_vti = 0; m_dpr = 0; m_ipriom = 0; m_iid = '0; m_iprio = '0;
        end else begin
            m_gen = n_gen;
            m_vpend = n_vp;
            if (wok && csr_sel == 3'd0) m_ven = csr_wdata & VEN_WR;
            if (wok && csr_sel == 3'd2) begin
                m_vti = csr_wdata[30]; m_iid = csr_wdata[21:16];
                m_dpr = csr_wdata[9]; m_ipriom = csr_wdata[8]; m_iprio = csr_wdata[7:0];
            end
        end
        @(negedge clk);
    endtask

    task automatic acc(input logic rq, input logic w, input logic [2:0] s,
                       input logic [63:0] d, input logic g);
        csr_req = rq; csr_we = w; csr_sel = s; csr_wdata = d; guest_mode = g;
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_ven = '0; m_vpend = '0; m_gen = '0;
        m_vti = 0; m_dpr = 0; m_ipriom = 0; m_iid = '0; m_iprio = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        step();
        rst = 1'b0;
        // R11 reset state
        acc(1, 0, 3'd1, '0, 0); #1 chk("R11 vpend after reset", csr_rdata, 64'h0); step();
        // R4 vie writable mask
        acc(1, 1, 3'd0, '1, 0); step();
        acc(1, 0, 3'd0, '0, 0); #1 chk("R4 vie readback", csr_rdata, VEN_WR); step();
        // R5 vip writable mask
        acc(1, 1, 3'd1, '1, 0); step();
        acc(1, 0, 3'd1, '0, 0); #1 chk("R5 vip readback", csr_rdata, VP_WR); step();
        // R2/R3 local sources, guest enable writes
        sup_pend = 64'hA5A5_5A5A_F0F0_0F0F; sup_en = 64'h3C3C_C3C3_6969_9696;
        acc(1, 1, 3'd4, '1, 1); step();
        acc(1, 0, 3'd4, '0, 1); #1 chk("R2 guest enable own bits", csr_rdata, VEN_WR); step();
        // R9 low mapping and R1 delegation
        deleg_mask = 64'h0000_00F0_0000_F444;
        acc(1, 0, 3'd3, '0, 1); step();
        acc(1, 1, 3'd3, 64'h0, 1); step();
        acc(1, 0, 3'd1, '0, 0); step();
        // R10 source switch back to local: enable reads zero
        deleg_mask = 64'h0;
        acc(1, 0, 3'd4, '0, 1); #1 chk("R10 enable cleared after switch", csr_rdata & 64'h0000_00F0_0000_E000, 64'h0); step();
        // R8 sticky: writes elsewhere keep vip
        acc(1, 1, 3'd1, '1, 0); step();
        acc(1, 1, 3'd0, 64'h0, 0); step();
        acc(1, 1, 3'd4, 64'h0, 1); step();
        acc(1, 0, 3'd1, '0, 0); #1 chk("R8 sticky vip held", csr_rdata, VP_WR); step();
        // R6 control layout
        acc(1, 1, 3'd2, '1, 0); step();
        acc(1, 0, 3'd2, '0, 0); #1 chk("R6 control readback", csr_rdata, 64'h0000_0000_403F_03FF); step();
        // R7 trap cases with VTI=1
        acc(1, 0, 3'd3, '0, 1); #1 chk("R7 guest pend read traps", {63'b0, virt_instr_trap}, 64'h1); step();
        acc(1, 0, 3'd5, '0, 1); #1 chk("R7 tcmp read no trap", {63'b0, virt_instr_trap}, 64'h0); step();
        acc(1, 1, 3'd5, '1, 1); #1 chk("R7 tcmp write traps", {63'b0, virt_instr_trap}, 64'h1); step();
        acc(1, 1, 3'd3, '0, 1); step();
        acc(1, 0, 3'd3, '0, 0); #1 chk("R7 host no trap, trapped write lost", {63'b0, virt_instr_trap}, 64'h0); step();
        acc(1, 0, 3'd6, '0, 0); #1 chk("R11 unused select reads zero", csr_rdata, 64'h0); step();
        // random traffic
        for (int n = 0; n < 3000; n++) begin
            rst = ($urandom_range(0, 199) == 0);
            if ($urandom_range(0, 3) == 0) deleg_mask = {$urandom, $urandom};
            sup_pend = {$urandom, $urandom};
            sup_en   = {$urandom, $urandom};
            acc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)),
                {$urandom, $urandom}, $urandom_range(0, 1) == 1);
            step();
        end
        rst = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule